// File: doc/BRIEF.md
# Time-Shared Second-Order-Section IIR Engine

The engine is a sixth-order recursive low-pass filter built as a cascade of three direct-form-II second-order sections. All sections share one multiply-accumulate datapath. For each accepted sample, a sequencer steps that datapath through the sections one after another. The two delay states of each section, the sample fed to each section and the result each section produces are kept in a small memory addressed by section number, not in per-section registers.

Samples are 16-bit two's-complement values, read as fractions with 15 fractional bits. Inside the engine, words are 25 bits wide with the same 15 fractional bits, and coefficients are 17 bits wide with 15 fractional bits. Every narrowing step rounds to nearest with ties to even, then clamps to the target width. The last section's result is multiplied by a programmable scale before it leaves the block.

Coefficients sit in a small register file. They are loaded through a write port while the engine is idle. A caller presents a sample with a strobe and waits for the result strobe. The engine holds a busy flag for the whole multi-cycle sequence.

Top module: `sos_iir_engine`

## Requirements
- R1: After reset, every section's feed-forward tap b0 and the output scale hold 1.0 (32768), all other coefficients hold 0, and all section states are 0. So a sample passes through unchanged, and busy, out_valid and out_data all read 0.
- R2: A sample is taken only at a rising edge where in_valid is high and busy is low. busy is high from the next cycle until the result appears. in_valid while busy is ignored: it produces no extra result and leaves the pending result unchanged.
- R3: out_valid is a one-cycle pulse exactly 19 cycles after the accepting edge (six steps per section plus one output step). out_data keeps its value between pulses.
- R4: Each section computes w = Q(x·2^15 − a1·w1 − a2·w2) and then y = Q(b0·w + b1·w1 + b2·w2). After that, w2 takes w1 and w1 takes w. Section 0 receives the sample sign-extended. Section k receives the y of section k−1. States persist from one sample to the next.
- R5: Q shifts right by 15 bits and rounds. A remainder of exactly one half rounds to the even neighbour (for example 1.5→2, 2.5→2, −1.5→−2, −0.5→0).
- R6: The section states w and results y clamp to the 25-bit range [−2^24, 2^24−1].
- R7: The output is Q(y_last·scale), clamped to the 16-bit range [−32768, 32767].
- R8: Coefficient address 5·s+i selects section s (0..2), where tap i is 0=b0, 1=b1, 2=b2, 3=a1, 4=a2. Address 15 is the output scale. A write at an edge where a sample is also accepted already applies to that sample.
- R9: A coefficient write at an edge where busy is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed input sample, 15 fractional bits |
| busy | output | 1 | High while a sample is being processed |
| out_valid | output | 1 | Result strobe, one cycle |
| out_data | output | 16 | Signed filtered result, held between strobes |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 4 | Coefficient address (5·section + tap, 15 = scale) |
| cfg_wdata | input | 17 | Signed coefficient, 15 fractional bits |

## Verification
A coefficient write and a sample acceptance can happen at the same clock edge. The bench drives cfg_we and in_valid in the same cycle, with a new output scale, and expects the scaled value on that same sample. It also places writes and repeated in_valid pulses inside the busy window. The reference model accepts a write only when it is itself idle, and it is compared against busy, out_valid and out_data at every clock. A write that slips through or a sample taken while busy therefore shows up as a mismatch on a later result.

// File: rtl/sos_pkg.sv
package sos_pkg;

   // Engine-level sequencing
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_OUT
   } eng_state_t;

   // Per-section steps on the shared datapath
   typedef enum logic [2:0] {
      PH_FB1,
      PH_FB2,
      PH_FF0,
      PH_FF1,
      PH_FF2,
      PH_WB
   } sec_phase_t;

   // Accumulator operations
   typedef enum logic [2:0] {
      MAC_HOLD,
      MAC_SEED_SUB,
      MAC_SUB,
      MAC_LOAD,
      MAC_ADD
   } mac_op_t;

   localparam int unsigned TAPS_PER_SEC   = 5;
   localparam int unsigned PHASES_PER_SEC = 6;

   localparam int unsigned TAP_B0 = 0;
   localparam int unsigned TAP_B1 = 1;
   localparam int unsigned TAP_B2 = 2;
   localparam int unsigned TAP_A1 = 3;
   localparam int unsigned TAP_A2 = 4;

endpackage

// File: rtl/sos_cround_sat.sv
module sos_cround_sat #(
   parameter int unsigned IN_W  = 44,
   parameter int unsigned SHIFT = 15,
   parameter int unsigned OUT_W = 25
)(
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int unsigned Q_W = IN_W - SHIFT;
   localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};
   localparam logic signed [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic signed [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

   if (SHIFT < 2) begin : g_bad_shift
      $error("sos_cround_sat: SHIFT must be at least 2");
   end
   if (Q_W < OUT_W) begin : g_bad_width
      $error("sos_cround_sat: IN_W - SHIFT must cover OUT_W");
   end

   logic [Q_W-1:0]   q;
   logic [SHIFT-1:0] rem;
   logic             up;
   logic [Q_W:0]     qr;
   logic             ovf;

   assign q   = din[IN_W-1:SHIFT];
   assign rem = din[SHIFT-1:0];
   assign up  = (rem > HALF) || ((rem == HALF) && q[0]);
   assign qr  = {q[Q_W-1], q} + {{Q_W{1'b0}}, up};
   assign ovf = !((&qr[Q_W:OUT_W-1]) || !(|qr[Q_W:OUT_W-1]));

   always_comb begin
      if (ovf) dout = qr[Q_W] ? NEG_LIM : POS_LIM;
      else     dout = qr[OUT_W-1:0];
   end
endmodule

// File: rtl/sos_mac.sv
module sos_mac import sos_pkg::*; #(
   parameter int unsigned A_W   = 25,
   parameter int unsigned B_W   = 17,
   parameter int unsigned FRAC  = 15,
   parameter int unsigned ACC_W = A_W + B_W + 2
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  mac_op_t                    op,
   input  logic signed [A_W-1:0]      opa,
   input  logic signed [B_W-1:0]      opb,
   input  logic signed [A_W-1:0]      seed,
   output logic signed [A_W+B_W-1:0]  prod,
   output logic signed [ACC_W-1:0]    acc
);
   localparam int unsigned PROD_W = A_W + B_W;

   if (ACC_W <= PROD_W || ACC_W <= A_W + FRAC) begin : g_bad_acc
      $error("sos_mac: accumulator too narrow");
   end

   logic signed [PROD_W-1:0] pa, pb;
   logic signed [ACC_W-1:0]  prod_x, seed_x, acc_d;

   assign pa     = {{B_W{opa[A_W-1]}}, opa};
   assign pb     = {{A_W{opb[B_W-1]}}, opb};
   assign prod   = pa * pb;
   assign prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
   assign seed_x = {{(ACC_W-A_W-FRAC){seed[A_W-1]}}, seed, {FRAC{1'b0}}};

   always_comb begin
      unique case (op)
         MAC_SEED_SUB: acc_d = seed_x - prod_x;
         MAC_SUB:      acc_d = acc - prod_x;
         MAC_LOAD:     acc_d = prod_x;
         MAC_ADD:      acc_d = acc + prod_x;
         default:      acc_d = acc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc_d;
   end
endmodule

// File: rtl/sos_coef_bank.sv
module sos_coef_bank import sos_pkg::*; #(
   parameter int unsigned N_SEC  = 3,
   parameter int unsigned COEF_W = 17,
   parameter int unsigned FRAC   = 15,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned SEC_W  = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic signed [COEF_W-1:0]  wdata,
   input  logic [SEC_W-1:0]          sel_sec,
   output logic signed [COEF_W-1:0]  b0,
   output logic signed [COEF_W-1:0]  b1,
   output logic signed [COEF_W-1:0]  b2,
   output logic signed [COEF_W-1:0]  a1,
   output logic signed [COEF_W-1:0]  a2,
   output logic signed [COEF_W-1:0]  scale
);
   localparam int unsigned SCALE_IDX = N_SEC * TAPS_PER_SEC;
   localparam int unsigned N_COEF    = SCALE_IDX + 1;
   localparam logic signed [COEF_W-1:0] ONE =
      {{(COEF_W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

   if (COEF_W < FRAC + 2) begin : g_bad_coef
      $error("sos_coef_bank: COEF_W must hold the value 1.0");
   end
   if ((1 << ADDR_W) < N_COEF) begin : g_bad_addr
      $error("sos_coef_bank: ADDR_W too small for coefficient count");
   end

   logic signed [COEF_W-1:0] bank [N_COEF];

   function automatic logic signed [COEF_W-1:0] rst_val(int unsigned idx);
      if (idx == SCALE_IDX)               return ONE;
      if ((idx % TAPS_PER_SEC) == TAP_B0) return ONE;
      return '0;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned i = 0; i < N_COEF; i++) bank[i] <= rst_val(i);
      end else if (we) begin
         for (int unsigned i = 0; i < N_COEF; i++)
            if (addr == ADDR_W'(i)) bank[i] <= wdata;
      end
   end

   always_comb begin
      b0 = '0; b1 = '0; b2 = '0; a1 = '0; a2 = '0;
      for (int unsigned s = 0; s < N_SEC; s++) begin
         if (sel_sec == SEC_W'(s)) begin
            b0 = bank[s*TAPS_PER_SEC + TAP_B0];
            b1 = bank[s*TAPS_PER_SEC + TAP_B1];
            b2 = bank[s*TAPS_PER_SEC + TAP_B2];
            a1 = bank[s*TAPS_PER_SEC + TAP_A1];
            a2 = bank[s*TAPS_PER_SEC + TAP_A2];
         end
      end
   end

   assign scale = bank[SCALE_IDX];
endmodule

// File: rtl/sos_state_mem.sv
module sos_state_mem #(
   parameter int unsigned N_SEC = 3,
   parameter int unsigned ST_W  = 25,
   parameter int unsigned SEC_W = 2
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SEC_W-1:0]        rd_sec,
   input  logic                    smp_we,
   input  logic signed [ST_W-1:0]  smp_data,
   input  logic                    upd_we,
   input  logic signed [ST_W-1:0]  upd_w,
   input  logic signed [ST_W-1:0]  upd_y,
   output logic signed [ST_W-1:0]  w1_o,
   output logic signed [ST_W-1:0]  w2_o,
   output logic signed [ST_W-1:0]  in_o,
   output logic signed [ST_W-1:0]  last_o
);
   logic signed [ST_W-1:0] w1 [N_SEC];
   logic signed [ST_W-1:0] w2 [N_SEC];
   logic signed [ST_W-1:0] io [N_SEC+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned s = 0; s < N_SEC; s++) begin
            w1[s] <= '0;
            w2[s] <= '0;
         end
         for (int unsigned s = 0; s <= N_SEC; s++) io[s] <= '0;
      end else begin
         if (smp_we) io[0] <= smp_data;
         if (upd_we) begin
            for (int unsigned s = 0; s < N_SEC; s++) begin
               if (rd_sec == SEC_W'(s)) begin
                  w2[s]   <= w1[s];
                  w1[s]   <= upd_w;
                  io[s+1] <= upd_y;
               end
            end
         end
      end
   end

   always_comb begin
      w1_o = '0; w2_o = '0; in_o = '0;
      for (int unsigned s = 0; s < N_SEC; s++) begin
         if (rd_sec == SEC_W'(s)) begin
            w1_o = w1[s];
            w2_o = w2[s];
            in_o = io[s];
         end
      end
   end

   assign last_o = io[N_SEC];
endmodule

// File: rtl/sos_iir_engine.sv
module sos_iir_engine import sos_pkg::*; #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ST_W   = 25,
   parameter int unsigned FRAC   = 15,
   parameter int unsigned COEF_W = 17,
   parameter int unsigned N_SEC  = 3,
   parameter int unsigned ADDR_W = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [DATA_W-1:0]   in_data,
   output logic                       busy,
   output logic                       out_valid,
   output logic signed [DATA_W-1:0]   out_data,
   input  logic                       cfg_we,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic signed [COEF_W-1:0]   cfg_wdata
);
   localparam int unsigned SEC_W  = (N_SEC > 1) ? $clog2(N_SEC) : 1;
   localparam int unsigned PROD_W = ST_W + COEF_W;
   localparam int unsigned ACC_W  = PROD_W + 2;

   if (N_SEC < 1) begin : g_bad_nsec
      $error("sos_iir_engine: N_SEC must be at least 1");
   end
   if (ST_W <= DATA_W) begin : g_bad_state
      $error("sos_iir_engine: ST_W must exceed DATA_W");
   end
   if (FRAC >= COEF_W - 1) begin : g_bad_frac
      $error("sos_iir_engine: FRAC leaves no integer bit in coefficients");
   end

   eng_state_t               state;
   sec_phase_t               ph;
   logic [SEC_W-1:0]         sec;
   logic signed [ST_W-1:0]   w_reg;

   logic signed [COEF_W-1:0] c_b0, c_b1, c_b2, c_a1, c_a2, c_scale;
   logic signed [ST_W-1:0]   m_w1, m_w2, m_in, m_last;
   logic signed [ST_W-1:0]   smp_ext;

   mac_op_t                  mop;
   logic signed [ST_W-1:0]   mopa;
   logic signed [COEF_W-1:0] mopb;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  acc;

   logic signed [ST_W-1:0]   q_state;
   logic signed [DATA_W-1:0] q_out;

   logic accept, upd_we, idle;

   assign idle    = (state == ST_IDLE);
   assign busy    = !idle;
   assign accept  = in_valid && idle;
   assign upd_we  = (state == ST_RUN) && (ph == PH_WB);
   assign smp_ext = {{(ST_W-DATA_W){in_data[DATA_W-1]}}, in_data};

   sos_coef_bank #(
      .N_SEC(N_SEC), .COEF_W(COEF_W), .FRAC(FRAC), .ADDR_W(ADDR_W), .SEC_W(SEC_W)
   ) u_coef (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_we && idle), .addr(cfg_addr), .wdata(cfg_wdata),
      .sel_sec(sec),
      .b0(c_b0), .b1(c_b1), .b2(c_b2), .a1(c_a1), .a2(c_a2), .scale(c_scale)
   );

   sos_state_mem #(
      .N_SEC(N_SEC), .ST_W(ST_W), .SEC_W(SEC_W)
   ) u_mem (
      .clk(clk), .rst_n(rst_n), .rd_sec(sec),
      .smp_we(accept), .smp_data(smp_ext),
      .upd_we(upd_we), .upd_w(w_reg), .upd_y(q_state),
      .w1_o(m_w1), .w2_o(m_w2), .in_o(m_in), .last_o(m_last)
   );

   // Operand selection for the shared multiply-accumulate
   always_comb begin
      mop  = MAC_HOLD;
      mopa = m_last;
      mopb = c_scale;
      if (state == ST_RUN) begin
         unique case (ph)
            PH_FB1: begin mop = MAC_SEED_SUB; mopa = m_w1;    mopb = c_a1; end
            PH_FB2: begin mop = MAC_SUB;      mopa = m_w2;    mopb = c_a2; end
            PH_FF0: begin mop = MAC_LOAD;     mopa = q_state; mopb = c_b0; end
            PH_FF1: begin mop = MAC_ADD;      mopa = m_w1;    mopb = c_b1; end
            PH_FF2: begin mop = MAC_ADD;      mopa = m_w2;    mopb = c_b2; end
            default: begin mop = MAC_HOLD;    mopa = m_last;  mopb = c_scale; end
         endcase
      end
   end

   sos_mac #(
      .A_W(ST_W), .B_W(COEF_W), .FRAC(FRAC), .ACC_W(ACC_W)
   ) u_mac (
      .clk(clk), .rst_n(rst_n), .op(mop),
      .opa(mopa), .opb(mopb), .seed(m_in),
      .prod(prod), .acc(acc)
   );

   // One requantizer serves both the state w and the section result y
   sos_cround_sat #(.IN_W(ACC_W), .SHIFT(FRAC), .OUT_W(ST_W)) u_q_state (
      .din(acc), .dout(q_state)
   );

   sos_cround_sat #(.IN_W(PROD_W), .SHIFT(FRAC), .OUT_W(DATA_W)) u_q_out (
      .din(prod), .dout(q_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ph        <= PH_FB1;
         sec       <= '0;
         w_reg     <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state <= ST_RUN;
                  sec   <= '0;
                  ph    <= PH_FB1;
               end
            end
            ST_RUN: begin
               unique case (ph)
                  PH_FB1: ph <= PH_FB2;
                  PH_FB2: ph <= PH_FF0;
                  PH_FF0: begin
                     w_reg <= q_state;
                     ph    <= PH_FF1;
                  end
                  PH_FF1: ph <= PH_FF2;
                  PH_FF2: ph <= PH_WB;
                  default: begin
                     ph <= PH_FB1;
                     if (sec == SEC_W'(N_SEC-1)) state <= ST_OUT;
                     else                        sec   <= sec + 1'b1;
                  end
               endcase
            end
            default: begin
               out_data  <= q_out;
               out_valid <= 1'b1;
               state     <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/sos_iir_engine_chk.sv
module sos_iir_engine_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned N_SEC  = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              busy,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data
);
   localparam int unsigned LAT   = N_SEC * 6 + 1;
   localparam int unsigned CNT_W = $clog2(LAT + 2) + 1;

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (in_valid && !busy)        cnt <= CNT_W'(1);
      else if (cnt == CNT_W'(LAT + 1))   cnt <= '0;
      else if (cnt != '0)                cnt <= cnt + 1'b1;
   end

   // R2: acceptance raises busy
   p_busy_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy) |=> busy);

   // R2: busy stays high over the whole sequence
   p_busy_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt != '0) && (cnt <= CNT_W'(LAT))) |-> busy);

   // R2: the engine is idle when its result is shown
   p_idle_at_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !busy);

   // R3: result only at the fixed latency
   p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cnt == CNT_W'(LAT + 1)));

   // R3: result never missing at the fixed latency
   p_result_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(LAT + 1)) |-> out_valid);

   // R3: single-cycle strobe
   p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R3: output word held between strobes
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
endmodule

bind sos_iir_engine sos_iir_engine_chk #(.DATA_W(DATA_W), .N_SEC(N_SEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_sos_iir_engine.sv
module tb_sos_iir_engine;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic               busy;
   logic               out_valid;
   logic signed [15:0] out_data;
   logic               cfg_we = 1'b0;
   logic [3:0]         cfg_addr = '0;
   logic signed [16:0] cfg_wdata = '0;

   always #4 clk = ~clk;   // 125 MHz

   sos_iir_engine dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .busy(busy), .out_valid(out_valid), .out_data(out_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
   );

   int    nchk = 0;
   int    nerr = 0;
   string cur_tag = "R4";
   bit    cmp_on = 1'b0;

   // ---------------- behavioural reference ----------------
   int     mc [16];
   longint mw1 [3];
   longint mw2 [3];
   int     m_left = 0;
   longint m_pend = 0;
   bit     e_valid = 0;
   longint e_data = 0;

   function automatic longint qs(longint v, int w);
      longint q, rem, hi, lo;
      q   = v >>> 15;
      rem = v - (q <<< 15);
      if (rem > 16384 || (rem == 16384 && q[0])) q = q + 1;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -hi - 1;
      if (q > hi) q = hi;
      if (q < lo) q = lo;
      return q;
   endfunction

   function automatic longint model_sample(longint x);
      longint v, w, y;
      v = x;
      for (int s = 0; s < 3; s++) begin
         w = qs((v <<< 15) - longint'(mc[5*s+3]) * mw1[s] - longint'(mc[5*s+4]) * mw2[s], 25);
         y = qs(longint'(mc[5*s]) * w + longint'(mc[5*s+1]) * mw1[s]
                + longint'(mc[5*s+2]) * mw2[s], 25);
         mw2[s] = mw1[s];
         mw1[s] = w;
         v = y;
      end
      return qs(v * longint'(mc[15]), 16);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mc[i] = (i % 5 == 0) ? 32768 : 0;
         for (int s = 0; s < 3; s++) begin mw1[s] = 0; mw2[s] = 0; end
         m_left = 0; e_valid = 0; e_data = 0;
      end else begin
         if (cfg_we && m_left == 0) mc[cfg_addr] = int'(cfg_wdata);
         if (m_left > 0) begin
            m_left = m_left - 1;
            if (m_left == 0) begin e_valid = 1; e_data = m_pend; end
            else e_valid = 0;
         end else begin
            e_valid = 0;
            if (in_valid) begin
               m_pend = model_sample(longint'(in_data));
               m_left = 19;
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         nchk++;
         if (busy !== (m_left != 0)) begin
            nerr++;
            $display("FAIL R2 busy actual %0d expected %0d", busy, (m_left != 0));
         end
         nchk++;
         if (out_valid !== e_valid) begin
            nerr++;
            $display("FAIL R3 out_valid actual %0d expected %0d", out_valid, e_valid);
         end
         if (e_valid) begin
            nchk++;
            if (longint'(out_data) != e_data) begin
               nerr++;
               $display("FAIL %s out_data actual %0d expected %0d", cur_tag, out_data, e_data);
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 17'(v);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_result(output longint got);
      got = 0;
      for (int i = 0; i < 40; i++) begin
         if (out_valid) begin got = longint'(out_data); break; end
         @(negedge clk);
      end
   endtask

   task automatic run_sample(input int x, output longint got);
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'(x);
      @(negedge clk);
      in_valid = 1'b0;
      wait_result(got);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   bit finished = 1'b0;
   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL R3 watchdog expired actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      longint got;
      int pulses;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;

      // R1: reset state and pass-through defaults
      check("R1 busy after reset", busy, 0);
      check("R1 out_valid after reset", out_valid, 0);
      check("R1 out_data after reset", out_data, 0);
      run_sample(1234, got);   check("R1 pass-through", got, 1234);
      run_sample(-32768, got); check("R1 pass-through min", got, -32768);

      // R5: ties go to even (section 0 gain 0.5)
      cur_tag = "R5";
      wr(0, 16384);
      run_sample(3, got);  check("R5 1.5", got, 2);
      run_sample(5, got);  check("R5 2.5", got, 2);
      run_sample(-3, got); check("R5 -1.5", got, -2);
      run_sample(7, got);  check("R5 3.5", got, 4);
      run_sample(1, got);  check("R5 0.5", got, 0);
      run_sample(-1, got); check("R5 -0.5", got, 0);
      wr(0, 32768);

      // R8: address map
      cur_tag = "R8";
      wr(5, 16384);
      run_sample(1000, got);  check("R8 section1 b0", got, 500);
      wr(5, 32768);
      wr(10, 16384);
      run_sample(-1000, got); check("R8 section2 b0", got, -500);
      wr(10, 32768);
      // R8: write and acceptance at the same edge
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'd15; cfg_wdata = 17'sd16384;
      in_valid = 1'b1; in_data = 16'sd1000;
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0;
      wait_result(got); check("R8 same-edge scale write", got, 500);
      wr(15, 32768);

      // R9: write while busy is discarded
      cur_tag = "R9";
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'sd1000;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 17'sd0;
      @(negedge clk);
      cfg_we = 1'b0;
      wait_result(got);       check("R9 pending result", got, 1000);
      run_sample(1000, got);  check("R9 b0 unchanged", got, 1000);

      // R2: in_valid while busy is ignored
      cur_tag = "R2";
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'sd100;
      @(negedge clk);
      in_data = 16'sd999;
      repeat (12) @(negedge clk);
      in_valid = 1'b0;
      wait_result(got); check("R2 first sample kept", got, 100);
      pulses = 0;
      repeat (25) begin @(negedge clk); if (out_valid) pulses++; end
      check("R2 no extra result", pulses, 0);

      // R7: output scale and clamp
      cur_tag = "R7";
      wr(15, 65535);
      run_sample(32767, got);  check("R7 clamp high", got, 32767);
      run_sample(-32768, got); check("R7 clamp low", got, -32768);
      run_sample(100, got);    check("R7 scaled", got, 200);
      wr(15, 32768);

      // R6: state clamp, seen through a 1-LSB output scale
      cur_tag = "R6";
      wr(3, -65536); wr(15, 1);
      repeat (14) run_sample(32767, got);
      check("R6 state clamp high", got, 512);
      cmp_on = 1'b0; do_reset(); cmp_on = 1'b1;
      wr(3, -65536); wr(15, 1);
      repeat (14) run_sample(-32768, got);
      check("R6 state clamp low", got, -512);
      cmp_on = 1'b0; do_reset(); cmp_on = 1'b1;

      // R4: filtering against the reference model
      cur_tag = "R4";
      wr(0, 2048);  wr(1, 4096);  wr(2, 2048);  wr(3, -52000); wr(4, 21000);
      wr(5, 4096);  wr(6, 8192);  wr(7, 4096);  wr(8, -45000); wr(9, 17500);
      wr(10, 8192); wr(11, 16384); wr(12, 8192); wr(13, -30000); wr(14, 9000);
      wr(15, 45000);
      run_sample(32767, got);                        // impulse
      for (int i = 0; i < 30; i++) run_sample(0, got);
      for (int i = 0; i < 30; i++) run_sample(500, got);   // step
      check("R4 step settles nonzero", (got != 0), 1);
      @(negedge clk);                                 // random burst
      in_valid = 1'b1;
      for (int i = 0; i < 800; i++) begin
         in_data = 16'($urandom);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (25) @(negedge clk);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule